// File: doc/BRIEF.md
# Buffered SPI Master

This block is a register-mapped SPI master for a 32-bit peripheral bus. Software queues bytes in a transmit queue. The shift engine sends each byte on SCLK/MOSI and captures one byte from MISO in return. Captured bytes collect in a receive queue, which software drains by reading the receive-data register. Each queue holds `FIFO_DEPTH` bytes.

A control register holds an inhibit bit that stops the engine from starting new bytes. It also has two self-clearing bits that empty either queue. A slave-select register drives active-low chip selects. A key-protected register resets the whole block. Pulses and levels are exported for an interrupt block placed next to this one.

Register offsets (byte address on `req_addr`): 0x40 soft reset, 0x60 control, 0x64 status, 0x68 transmit data, 0x6C receive data, 0x70 slave select, 0x74 transmit occupancy, 0x78 receive occupancy. Offsets not listed read as 0, and writes to them have no effect.

Top module: `spim_top`

## Requirements
- R1: An access is accepted only when `req_be` is 4'hF. Any other byte-enable pattern leaves every register unchanged and produces no read response.
- R2: The status register reads {28'b0, tx_full, tx_empty, rx_full, rx_empty}: receive-empty at bit 0, receive-full at bit 1, transmit-empty at bit 2, transmit-full at bit 3. After reset it reads 0x5.
- R3: Writing transmit data queues the low byte. While control bit 8 (inhibit) is 1, no byte starts. Once it is 0, queued bytes are sent one after another until the queue is empty. `lvl_tx_empty` is high exactly when the transmit queue is empty.
- R4: Transfers use SPI mode 0 and send 8 bits per byte, most significant bit first. SCLK idles low, and each SCLK phase lasts `SCLK_HALF` clock cycles. MOSI changes only while SCLK is low, and MISO is sampled as SCLK rises.
- R5: Every sent byte yields one received byte. While there is room it is appended to the receive queue, and receive-data reads return the bytes in arrival order in bits 7:0. `lvl_rx_nonempty` reflects a non-empty queue.
- R6: If the receive queue is full when a byte completes, and no receive-data read frees a slot in that same cycle, the byte is dropped and `ev_overrun` pulses for one cycle. `lvl_rx_full` is high when the queue holds `FIFO_DEPTH` bytes.
- R7: Reading receive data while the receive queue is empty returns 0xDEADBEEF and changes no queue state.
- R8: A control write with bit 5 set empties the transmit queue, and one with bit 6 set empties the receive queue. Both bits always read back as 0. The other control bits read back as written.
- R9: Writing exactly 0x0000000A to the soft-reset register returns control to 0, slave select to all ones, and both queues to empty, and stops the engine. Any other value written there has no effect.
- R10: Slave select resets to all ones. `cs_n[i]` is low exactly when bit i of the slave-select register is 0.
- R11: Each occupancy register reads the byte count of its queue minus one, or 0 when the queue is empty.
- R12: `busy` is high for exactly 16*`SCLK_HALF` cycles per byte. `ev_rx_byte` pulses in the last of those cycles. The next byte is taken from the queue only after `busy` has dropped.
- R13: Writes to the status register have no effect. A transmit-data write while the transmit queue is full is dropped, unless the engine takes a byte from the queue in that same cycle.
- R14: A read returns its data on `rsp_rdata` with `rsp_valid` high in the cycle after the request. `rsp_valid` is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset of the register |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the request) |
| rsp_rdata | output | 32 | Read data |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| busy | output | 1 | A byte is being shifted |
| ev_rx_byte | output | 1 | Pulse: byte transfer completed |
| ev_overrun | output | 1 | Pulse: received byte dropped, queue full |
| lvl_rx_nonempty | output | 1 | Receive queue holds data |
| lvl_rx_full | output | 1 | Receive queue full |
| lvl_tx_empty | output | 1 | Transmit queue empty |

## Verification
Two receive-queue operations can fall in the same cycle: a byte completing into a full receive queue, and a software read popping that queue. Whether the byte is kept or dropped with an overrun depends on that coincidence. The bench fills the receive queue and then issues receive-data reads every other cycle while further bytes complete, so that some reads land exactly on a completion cycle. A cycle-accurate reference model predicts from its own byte timer which completions coincide with a pop. It judges `ev_overrun`, the queue flags and the order of the later read data against that prediction on every clock.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam logic [6:0] OFF_SRST  = 7'h40;
   localparam logic [6:0] OFF_CTRL  = 7'h60;
   localparam logic [6:0] OFF_STAT  = 7'h64;
   localparam logic [6:0] OFF_TXD   = 7'h68;
   localparam logic [6:0] OFF_RXD   = 7'h6C;
   localparam logic [6:0] OFF_SSEL  = 7'h70;
   localparam logic [6:0] OFF_TXOCC = 7'h74;
   localparam logic [6:0] OFF_RXOCC = 7'h78;

   localparam logic [31:0] SRST_KEY   = 32'h0000_000A;
   localparam logic [31:0] EMPTY_READ = 32'hDEAD_BEEF;

   localparam int CB_TXFLUSH = 5;
   localparam int CB_RXFLUSH = 6;
   localparam int CB_INHIBIT = 8;

   typedef struct packed {
      logic tx_full;
      logic tx_empty;
      logic rx_full;
      logic rx_empty;
   } spim_stat_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic                       pop,
   input  logic [WIDTH-1:0]           wdata,
   output logic [WIDTH-1:0]           rdata,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign rdata   = mem[rp_q];
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp_q] <= wdata;
   end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       busy,
   output logic       sclk,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx_byte
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF < 1) begin : g_bad_half
      $error("spim_shifter: HALF must be at least 1");
   end

   logic       busy_q, sclk_q, tick;
   logic [2:0] bit_q;
   logic [7:0] sh_tx_q, sh_rx_q;

   if (HALF == 1) begin : g_nodiv
      assign tick = busy_q;
   end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       cnt_q <= '0;
         else if (!busy_q || abort || tick) cnt_q <= '0;
         else                              cnt_q <= cnt_q + 1'b1;
      end
      assign tick = busy_q & (cnt_q == CW'(HALF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         sclk_q  <= 1'b0;
         bit_q   <= '0;
         sh_tx_q <= '0;
         sh_rx_q <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
      end else if (start) begin
         busy_q  <= 1'b1;
         sclk_q  <= 1'b0;
         bit_q   <= '0;
         sh_tx_q <= tx_byte;
      end else if (tick) begin
         if (!sclk_q) begin
            sclk_q  <= 1'b1;
            sh_rx_q <= {sh_rx_q[6:0], miso};
         end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
               busy_q <= 1'b0;
            end else begin
               bit_q   <= bit_q + 1'b1;
               sh_tx_q <= {sh_tx_q[6:0], 1'b0};
            end
         end
      end
   end

   assign busy    = busy_q;
   assign sclk    = sclk_q;
   assign mosi    = busy_q & sh_tx_q[7];
   assign done    = tick & sclk_q & (bit_q == 3'd7);
   assign rx_byte = sh_rx_q;
endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int NUM_CS     = 1,
   parameter int FIFO_DEPTH = 256,
   parameter int SCLK_HALF  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [6:0]        req_addr,
   input  logic [3:0]        req_be,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n,
   output logic              busy,
   output logic              ev_rx_byte,
   output logic              ev_overrun,
   output logic              lvl_rx_nonempty,
   output logic              lvl_rx_full,
   output logic              lvl_tx_empty
);
   localparam int CW = $clog2(FIFO_DEPTH) + 1;

   if (NUM_CS < 1 || NUM_CS > 32) begin : g_bad_cs
      $error("spim_top: NUM_CS must lie in 1..32");
   end

   logic          acc, wr, rd, srst, ctrl_wr, inhibit;
   logic          tx_flush, rx_flush, tx_push, tx_pop, rx_push, rx_pop, start;
   logic          tx_full, tx_empty, rx_full, rx_empty, done;
   logic [7:0]    tx_rdata, rx_rdata, rx_byte;
   logic [CW-1:0] tx_count, rx_count;
   logic [31:0]   ctrl_q, ssel_q, rdata_nxt;
   spim_stat_t    stat;

   // request decode
   assign acc     = req_valid & (req_be == 4'hF);
   assign wr      = acc & req_write;
   assign rd      = acc & ~req_write;
   assign srst    = wr & (req_addr == OFF_SRST) & (req_wdata == SRST_KEY);
   assign ctrl_wr = wr & (req_addr == OFF_CTRL);
   assign inhibit = ctrl_q[CB_INHIBIT];

   assign tx_flush = srst | (ctrl_wr & req_wdata[CB_TXFLUSH]);
   assign rx_flush = srst | (ctrl_wr & req_wdata[CB_RXFLUSH]);
   assign tx_push  = wr & (req_addr == OFF_TXD);
   assign rx_pop   = rd & (req_addr == OFF_RXD) & ~rx_empty;
   assign start    = ~busy & ~tx_empty & ~inhibit & ~tx_flush;
   assign tx_pop   = start;
   assign rx_push  = done & ~rx_flush;
   assign ev_overrun = rx_push & rx_full & ~rx_pop;
   assign ev_rx_byte = done;

   spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .pop(tx_pop),
      .wdata(req_wdata[7:0]), .rdata(tx_rdata), .count(tx_count),
      .full(tx_full), .empty(tx_empty));

   spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .pop(rx_pop),
      .wdata(rx_byte), .rdata(rx_rdata), .count(rx_count),
      .full(rx_full), .empty(rx_empty));

   spim_shifter #(.HALF(SCLK_HALF)) u_shift (
      .clk(clk), .rst_n(rst_n), .abort(srst), .start(start), .tx_byte(tx_rdata),
      .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi), .done(done),
      .rx_byte(rx_byte));

   // control and slave-select registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ssel_q <= '1;
      end else if (srst) begin
         ctrl_q <= '0;
         ssel_q <= '1;
      end else begin
         if (ctrl_wr) begin
            ctrl_q <= req_wdata;
            ctrl_q[CB_TXFLUSH] <= 1'b0;
            ctrl_q[CB_RXFLUSH] <= 1'b0;
         end
         if (wr && req_addr == OFF_SSEL) ssel_q <= req_wdata;
      end
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = ssel_q[i];
   end

   assign stat = '{tx_full: tx_full, tx_empty: tx_empty,
                   rx_full: rx_full, rx_empty: rx_empty};

   function automatic logic [31:0] occ(input logic [CW-1:0] c);
      return (c == '0) ? 32'd0 : 32'(c) - 32'd1;
   endfunction

   always_comb begin
      case (req_addr)
         OFF_CTRL:  rdata_nxt = ctrl_q;
         OFF_STAT:  rdata_nxt = {28'd0, stat};
         OFF_RXD:   rdata_nxt = rx_empty ? EMPTY_READ : {24'd0, rx_rdata};
         OFF_SSEL:  rdata_nxt = ssel_q;
         OFF_TXOCC: rdata_nxt = occ(tx_count);
         OFF_RXOCC: rdata_nxt = occ(rx_count);
         default:   rdata_nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd;
         if (rd) rsp_rdata <= rdata_nxt;
      end
   end

   assign lvl_rx_nonempty = ~rx_empty;
   assign lvl_rx_full     = rx_full;
   assign lvl_tx_empty    = tx_empty;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
   parameter int NUM_CS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              sclk,
   input logic              mosi,
   input logic              ev_rx_byte,
   input logic              ev_overrun,
   input logic              lvl_rx_full,
   input logic              inhibit,
   input logic              srst,
   input logic [NUM_CS-1:0] cs_n
);
   AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !mosi));                                   // R4
   AST_MOSI_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mosi)) |-> !sclk);            // R4
   AST_NO_START_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(inhibit));                              // R3
   AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ev_overrun |-> (lvl_rx_full && ev_rx_byte));                   // R6
   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_byte |-> (busy && sclk));                                // R12
   AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(srst) |-> ((&cs_n) && !busy));                           // R9
endmodule

bind spim_top spim_checker #(.NUM_CS(NUM_CS)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .mosi(mosi),
   .ev_rx_byte(ev_rx_byte), .ev_overrun(ev_overrun), .lvl_rx_full(lvl_rx_full),
   .inhibit(inhibit), .srst(srst), .cs_n(cs_n));

// File: tb/spim_top_bench.sv
`timescale 1ns/1ps
module spim_top_bench;
   localparam int NCS = 2;
   localparam int D   = 256;
   localparam int H   = 3;
   localparam int BYTE_CYC = 16 * H;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, miso = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, sclk, mosi, busy, ev_rx_byte, ev_overrun;
   logic        lvl_rx_nonempty, lvl_rx_full, lvl_tx_empty;
   logic [31:0] rsp_rdata;
   logic [NCS-1:0] cs_n;

   spim_top #(.NUM_CS(NCS), .FIFO_DEPTH(D), .SCLK_HALF(H)) u_spim_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sclk(sclk), .mosi(mosi),
      .miso(miso), .cs_n(cs_n), .busy(busy), .ev_rx_byte(ev_rx_byte),
      .ev_overrun(ev_overrun), .lvl_rx_nonempty(lvl_rx_nonempty),
      .lvl_rx_full(lvl_rx_full), .lvl_tx_empty(lvl_tx_empty));

   always #2.5 clk = ~clk;

   int n_vec = 0, n_bad = 0, ovr_seen = 0;
   string cur_tag = "R5";

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] resp(input int k);
      return 8'(k * 75 + 60);
   endfunction

   // reference model state
   logic [7:0]  txq[$], rxq[$];
   int          busy_cnt = 0, kidx = 0;
   logic [7:0]  cur_tx = '0;
   logic [31:0] m_ctrl = '0, m_ssr = '1, exp_rsp = '0;
   bit          exp_rsp_v = 0;
   string       exp_tag = "R5";

   always @(negedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         busy_cnt = 0; m_ctrl = '0; m_ssr = '1; exp_rsp_v = 0; miso = 1'b0;
      end else begin
         int el, bp, tx_n, rx_n;
         bit acc, wr, rd, srst, txfl, rxfl, done, rpop, start, ovr;
         logic [7:0] rb;
         el = BYTE_CYC - busy_cnt;
         bp = el / (2 * H);
         // outputs after the last edge
         chk("R10", 32'(cs_n), 32'(m_ssr[NCS-1:0]));
         chk("R12", 32'(busy), 32'(busy_cnt > 0));
         chk("R4 sclk", 32'(sclk), (busy_cnt > 0) ? 32'((el / H) % 2) : 32'd0);
         chk("R4 mosi", 32'(mosi), (busy_cnt > 0) ? 32'(cur_tx[7 - bp]) : 32'd0);
         chk("R5", 32'(lvl_rx_nonempty), 32'(rxq.size() > 0));
         chk("R6", 32'(lvl_rx_full), 32'(rxq.size() == D));
         chk("R3", 32'(lvl_tx_empty), 32'(txq.size() == 0));
         chk("R14", 32'(rsp_valid), 32'(exp_rsp_v));
         if (exp_rsp_v) chk(exp_tag, rsp_rdata, exp_rsp);
         // slave drive for the coming edge
         rb = resp(kidx);
         miso = (busy_cnt > 0) ? rb[7 - bp] : 1'b0;
         // transition for the coming edge
         acc  = req_valid && req_be == 4'hF;
         wr   = acc && req_write;
         rd   = acc && !req_write;
         srst = wr && req_addr == 7'h40 && req_wdata == 32'hA;
         txfl = srst || (wr && req_addr == 7'h60 && req_wdata[5]);
         rxfl = srst || (wr && req_addr == 7'h60 && req_wdata[6]);
         tx_n = txq.size(); rx_n = rxq.size();
         done = (busy_cnt == 1);
         rpop = rd && req_addr == 7'h6C && rx_n > 0;
         ovr  = done && !rxfl && rx_n == D && !rpop;
         start = (busy_cnt == 0) && tx_n > 0 && !m_ctrl[8] && !txfl;
         chk("R12 done", 32'(ev_rx_byte), 32'(done));
         chk("R6 overrun", 32'(ev_overrun), 32'(ovr));
         if (ev_overrun) ovr_seen++;
         exp_rsp_v = rd;
         exp_tag = cur_tag;
         if (rd) begin
            case (req_addr)
               7'h60: exp_rsp = m_ctrl;
               7'h64: exp_rsp = {28'd0, tx_n == D, tx_n == 0, rx_n == D, rx_n == 0};
               7'h6C: exp_rsp = (rx_n > 0) ? {24'd0, rxq[0]} : 32'hDEADBEEF;
               7'h70: exp_rsp = m_ssr;
               7'h74: exp_rsp = (tx_n > 0) ? 32'(tx_n - 1) : 32'd0;
               7'h78: exp_rsp = (rx_n > 0) ? 32'(rx_n - 1) : 32'd0;
               default: exp_rsp = '0;
            endcase
         end
         if (rpop) void'(rxq.pop_front());
         if (done && !rxfl && (rx_n < D || rpop)) rxq.push_back(resp(kidx));
         if (done) kidx++;
         if (busy_cnt > 0) busy_cnt--;
         if (start) begin
            cur_tx = txq.pop_front();
            busy_cnt = BYTE_CYC;
         end
         if (wr && req_addr == 7'h68 && (tx_n < D || start)) txq.push_back(req_wdata[7:0]);
         if (wr && req_addr == 7'h60) m_ctrl = req_wdata & ~32'h60;
         if (wr && req_addr == 7'h70) m_ssr = req_wdata;
         if (txfl) txq.delete();
         if (rxfl) rxq.delete();
         if (srst) begin
            busy_cnt = 0; m_ctrl = '0; m_ssr = '1;
         end
      end
   end

   task automatic bus(input bit w, input logic [6:0] a, input logic [31:0] d,
                      input logic [3:0] be = 4'hF);
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rdreg(input string tag, input logic [6:0] a);
      cur_tag = tag;
      bus(1'b0, a, 32'd0);
      @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (!busy && lvl_tx_empty) break;
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset", 32'(cs_n), 32'h3);
      rdreg("R2 reset status", 7'h64);
      // slave select
      bus(1'b1, 7'h70, 32'hFFFF_FFFE);
      @(negedge clk);
      chk("R10 select", 32'(cs_n), 32'h2);
      // partial byte enables ignored
      bus(1'b1, 7'h70, 32'h0, 4'h3);
      rdreg("R1", 7'h70);
      // status write ignored
      bus(1'b1, 7'h64, 32'hF);
      rdreg("R13 status", 7'h64);
      // inhibit holds bytes
      bus(1'b1, 7'h60, 32'h100);
      bus(1'b1, 7'h68, 32'hA5);
      bus(1'b1, 7'h68, 32'h3C);
      bus(1'b1, 7'h68, 32'h81);
      repeat (80) @(posedge clk);
      rdreg("R11 tx occ", 7'h74);
      rdreg("R3 status", 7'h64);
      bus(1'b1, 7'h60, 32'h0);
      wait_idle();
      rdreg("R11 rx occ", 7'h78);
      for (int i = 0; i < 3; i++) rdreg("R5 data", 7'h6C);
      rdreg("R7 empty read", 7'h6C);
      rdreg("R7 status", 7'h64);
      rdreg("R11 empty occ", 7'h78);
      // transmit queue full, then flushed
      bus(1'b1, 7'h60, 32'h100);
      for (int i = 0; i < D + 1; i++) bus(1'b1, 7'h68, 32'(i));
      rdreg("R13 tx full", 7'h64);
      rdreg("R11 tx occ full", 7'h74);
      bus(1'b1, 7'h60, 32'h120);
      rdreg("R8 ctrl", 7'h60);
      rdreg("R8 status", 7'h64);
      // receive overrun
      for (int i = 0; i < D; i++) bus(1'b1, 7'h68, 32'(i + 7));
      bus(1'b1, 7'h60, 32'h0);
      wait_idle();
      bus(1'b1, 7'h68, 32'h11);
      bus(1'b1, 7'h68, 32'h22);
      wait_idle();
      chk("R6 overrun count", 32'(ovr_seen), 32'd2);
      rdreg("R6 status", 7'h64);
      rdreg("R11 rx occ full", 7'h78);
      // completion and read in the same cycle
      for (int i = 0; i < 4; i++) bus(1'b1, 7'h68, 32'(i + 40));
      cur_tag = "R6 concurrent";
      for (int i = 0; i < 120; i++) bus(1'b0, 7'h6C, 32'd0);
      wait_idle();
      for (int i = 0; i < 20; i++) rdreg("R5 order", 7'h6C);
      // receive flush
      bus(1'b1, 7'h60, 32'h40);
      rdreg("R8 rx occ", 7'h78);
      rdreg("R8 rx status", 7'h64);
      // soft reset key
      bus(1'b1, 7'h70, 32'hFFFF_FFFC);
      bus(1'b1, 7'h60, 32'h100);
      bus(1'b1, 7'h68, 32'h5A);
      bus(1'b1, 7'h40, 32'h5);
      rdreg("R9 wrong key", 7'h60);
      chk("R9 wrong key cs", 32'(cs_n), 32'h0);
      bus(1'b1, 7'h40, 32'hA);
      @(negedge clk);
      chk("R9 cs", 32'(cs_n), 32'h3);
      rdreg("R9 ctrl", 7'h60);
      rdreg("R9 ssel", 7'h70);
      rdreg("R9 status", 7'h64);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule